// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that finishes each instruction in one clock cycle. It runs a small register-to-register instruction subset: three-operand arithmetic and logic (add, subtract, AND, OR, signed set-less-than), word load, word store and branch-if-equal. A single ALU does the work for all of them. It forms the load/store effective address, it computes the arithmetic result, and it subtracts the two operands of a branch so that its zero flag decides the branch. Multiplexers pick the second ALU operand, the value written back and the next program counter. A separate adder forms the branch target.

The instruction store and the data store are internal word arrays. Both are loaded through a fill stream while the core is held in reset. The fill stream has a valid/ready handshake. `fill_ready` is high only while `rst_n` is low. A word is taken on a rising edge where both `fill_valid` and `fill_ready` are high. A fill offered while the core runs sees back-pressure and changes nothing. Once reset is released, the core starts at address 0.

Each cycle the environment can watch the program counter, the register-file write port and the data-store write port. All three are presented combinationally for the instruction that executes in that cycle.

Top module: `onecycle_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0, both write strobes are low and `fill_ready` is high. While the core runs, `fill_ready` is low and a fill offer leaves the stores unchanged.
- R2: Every instruction other than a taken branch advances `pc_o` by 4 at the next rising edge.
- R3: An instruction with opcode (bits 31:26) 0x00 writes the register named by bits 15:11. It uses the registers named by bits 25:21 (first operand) and bits 20:16 (second operand). The function code in bits 5:0 selects the operation: 0x20 add, 0x22 subtract (both wrap modulo 2^32), 0x24 AND, 0x25 OR, 0x2A signed less-than giving 1 or 0.
- R4: Register 0 reads as zero. Any instruction aimed at it leaves `rf_we_o` low.
- R5: Opcode 0x23 (load) writes the register named by bits 20:16 with the data-store word at the effective address. The effective address is the register named by bits 25:21 plus the sign-extended bits 15:0.
- R6: Opcode 0x2B (store) raises `dm_we_o` with `dm_addr_o` equal to the effective address and `dm_wdata_o` equal to the register named by bits 20:16. It writes no register, and a later load of that address returns the stored word.
- R7: Opcode 0x04 (branch) compares the registers named by bits 25:21 and 20:16. If they are equal, the next PC is PC+4 plus the sign-extended bits 15:0 shifted left by two; otherwise it is PC+4. A branch writes nothing.
- R8: Any other opcode, and opcode 0x00 with any other function code, writes nothing and advances the PC by 4.
- R9: `rf_we_o` and `dm_we_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; also opens the fill stream |
| fill_valid | input | 1 | Fill word offered |
| fill_ready | output | 1 | Fill word can be taken (core in reset) |
| fill_dmem | input | 1 | 1 selects the data store, 0 the instruction store |
| fill_addr | input | FILL_AW | Word index of the fill |
| fill_data | input | XLEN | Fill word |
| pc_o | output | XLEN | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | Register write happens at the next edge |
| rf_waddr_o | output | REG_AW | Destination register number |
| rf_wdata_o | output | XLEN | Value to be written to the register |
| dm_we_o | output | 1 | Data-store write happens at the next edge |
| dm_addr_o | output | XLEN | Effective byte address |
| dm_wdata_o | output | XLEN | Word to be stored |

## Verification
The ALU path is driven by eight operand words: zero, one, minus one, the largest and smallest signed values, a small positive and negative pair, and a mixed pattern. Each of the five operations is applied to every ordered pair of them. This separates signed from unsigned comparison, shows carry and borrow wrap, and catches a swapped operand or a wrong function code. A second program mixes loads and stores with positive and negative offsets and aims writes at register 0. It also runs an unknown opcode and an unknown function code, and offers a fill during the run. This tells write-back source selection, destination field selection and write suppression apart. A third program traces the PC through branches that are taken forward, not taken, taken backward and taken on equal non-zero operands. This distinguishes the offset scaling and the base address of the target adder from the zero-flag decision.

// File: rtl/onecycle_pkg.sv
package onecycle_pkg;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_fn_e;

  typedef struct packed {
    logic    reg_we;   // instruction writes a register
    logic    dst_rd;   // destination from bits 15:11 (else 20:16)
    logic    src_imm;  // second ALU operand is the immediate
    logic    wb_mem;   // write-back from data store (else ALU)
    logic    mem_we;   // instruction writes the data store
    logic    branch;   // branch-if-equal
    alu_fn_e fn;
  } ctl_t;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/op_decoder.sv
module op_decoder
  import onecycle_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl
);

  always_comb begin
    ctl = '{reg_we: 1'b0, dst_rd: 1'b0, src_imm: 1'b0, wb_mem: 1'b0,
            mem_we: 1'b0, branch: 1'b0, fn: ALU_ADD};
    unique case (opcode)
      OPC_RTYPE: begin
        ctl.dst_rd = 1'b1;
        ctl.reg_we = 1'b1;
        case (funct)
          FN_ADD:  ctl.fn = ALU_ADD;
          FN_SUB:  ctl.fn = ALU_SUB;
          FN_AND:  ctl.fn = ALU_AND;
          FN_OR:   ctl.fn = ALU_OR;
          FN_SLT:  ctl.fn = ALU_SLT;
          default: ctl.reg_we = 1'b0;
        endcase
      end
      OPC_LOAD: begin
        ctl.reg_we  = 1'b1;
        ctl.src_imm = 1'b1;
        ctl.wb_mem  = 1'b1;
      end
      OPC_STORE: begin
        ctl.src_imm = 1'b1;
        ctl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        ctl.fn     = ALU_SUB;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/regbank.sv
module regbank #(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [XLEN-1:0]   wdata,
  input  logic [REG_AW-1:0] raddr_a,
  input  logic [REG_AW-1:0] raddr_b,
  output logic [XLEN-1:0]   rdata_a,
  output logic [XLEN-1:0]   rdata_b
);

  localparam int NREGS = 1 << REG_AW;

  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import onecycle_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_fn_e         fn,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  always_comb begin
    unique case (fn)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/pc_unit.sv
module pc_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [XLEN-1:0] offset,
  output logic [XLEN-1:0] pc
);

  logic [XLEN-1:0] pc_seq;
  logic [XLEN-1:0] pc_tgt;

  assign pc_seq = pc + XLEN'(4);
  assign pc_tgt = pc_seq + {offset[XLEN-3:0], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= take ? pc_tgt : pc_seq;
  end

endmodule

// File: rtl/onecycle_core.sv
module onecycle_core
  import onecycle_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int REG_AW     = 5,
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 64,
  parameter int FILL_AW    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_valid,
  output logic               fill_ready,
  input  logic               fill_dmem,
  input  logic [FILL_AW-1:0] fill_addr,
  input  logic [XLEN-1:0]    fill_data,
  output logic [XLEN-1:0]    pc_o,
  output logic               rf_we_o,
  output logic [REG_AW-1:0]  rf_waddr_o,
  output logic [XLEN-1:0]    rf_wdata_o,
  output logic               dm_we_o,
  output logic [XLEN-1:0]    dm_addr_o,
  output logic [XLEN-1:0]    dm_wdata_o
);

  localparam int ILEN = 32;
  localparam int IAW  = $clog2(IMEM_WORDS);
  localparam int DAW  = $clog2(DMEM_WORDS);

  logic [ILEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0]   pc;
  logic [ILEN-1:0]   instr;
  ctl_t              ctl;
  logic [XLEN-1:0]   ra, rb, imm_sx, alu_b, alu_y, ld_word, wb_data;
  logic              alu_zero, br_taken, fill_fire;
  logic [REG_AW-1:0] dst;
  logic [DAW-1:0]    d_idx;

  // fill stream: accepted only while the core is held in reset
  assign fill_ready = !rst_n;
  assign fill_fire  = fill_valid && fill_ready;

  always_ff @(posedge clk) begin
    if (fill_fire && !fill_dmem) imem[fill_addr[IAW-1:0]] <= fill_data[ILEN-1:0];
  end

  assign instr = imem[pc[IAW+1:2]];

  op_decoder u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctl    (ctl)
  );

  regbank #(.XLEN(XLEN), .REG_AW(REG_AW)) u_rf (
    .clk     (clk),
    .we      (rf_we_o),
    .waddr   (dst),
    .wdata   (wb_data),
    .raddr_a (instr[25:21]),
    .raddr_b (instr[20:16]),
    .rdata_a (ra),
    .rdata_b (rb)
  );

  assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign alu_b  = ctl.src_imm ? imm_sx : rb;

  alu_unit #(.XLEN(XLEN)) u_alu (
    .a    (ra),
    .b    (alu_b),
    .fn   (ctl.fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data store: fill while in reset, store instructions while running
  assign d_idx   = alu_y[DAW+1:2];
  assign ld_word = dmem[d_idx];

  always_ff @(posedge clk) begin
    if (fill_fire && fill_dmem) dmem[fill_addr[DAW-1:0]] <= fill_data;
    else if (dm_we_o)           dmem[d_idx] <= rb;
  end

  assign wb_data  = ctl.wb_mem ? ld_word : alu_y;
  assign dst      = ctl.dst_rd ? instr[15:11] : instr[20:16];
  assign br_taken = ctl.branch && alu_zero;

  pc_unit #(.XLEN(XLEN)) u_pc (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (br_taken),
    .offset (imm_sx),
    .pc     (pc)
  );

  assign pc_o       = pc;
  assign rf_we_o    = ctl.reg_we && rst_n && (dst != '0);
  assign rf_waddr_o = dst;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = ctl.mem_we && rst_n;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rb;

  logic unused_bits;
  assign unused_bits = ^{pc[XLEN-1:IAW+2], pc[1:0], alu_y[XLEN-1:DAW+2],
                         alu_y[1:0], instr[10:6]};

endmodule

// File: rtl/onecycle_chk.sv
module onecycle_chk #(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   pc_o,
  input logic              rf_we_o,
  input logic [REG_AW-1:0] rf_waddr_o,
  input logic              dm_we_o,
  input logic              br_taken,
  input logic [15:0]       br_imm
);

  logic [XLEN-1:0] br_step;
  assign br_step = {{(XLEN-18){br_imm[15]}}, br_imm, 2'b00};

  AST_PC_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pc_o == '0)); // R1

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !br_taken |=> (pc_o == $past(pc_o) + XLEN'(4))); // R2

  AST_R0_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (rf_waddr_o != '0)); // R4

  AST_BR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> (pc_o == $past(pc_o) + XLEN'(4) + $past(br_step))); // R7

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we_o && dm_we_o)); // R9

endmodule

bind onecycle_core onecycle_chk #(.XLEN(XLEN), .REG_AW(REG_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc_o       (pc_o),
  .rf_we_o    (rf_we_o),
  .rf_waddr_o (rf_waddr_o),
  .dm_we_o    (dm_we_o),
  .br_taken   (br_taken),
  .br_imm     (instr[15:0])
);

// File: tb/sim_onecycle_core.sv
module sim_onecycle_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic        fill_dmem = 1'b0;
  logic [7:0]  fill_addr = '0;
  logic [31:0] fill_data = '0;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [4:0]  rf_waddr_o;
  logic        rf_we_o, dm_we_o;

  int checks = 0;
  int failures = 0;

  logic [31:0] prog  [256];
  logic [31:0] dinit [8];

  always #4 clk = ~clk;

  onecycle_core u0 (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_dmem(fill_dmem), .fill_addr(fill_addr), .fill_data(fill_data),
    .pc_o(pc_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  function automatic logic [31:0] alu_ref(int op, logic [31:0] a, logic [31:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic exp_pc(input logic [31:0] e, input string req);
    chk(pc_o === e, req, {32'd0, pc_o}, {32'd0, e});
  endtask

  task automatic exp_rf(input bit we, input int a, input logic [31:0] d, input string req);
    if (we)
      chk(rf_we_o === 1'b1 && rf_waddr_o === a[4:0] && rf_wdata_o === d, req,
          {26'd0, rf_we_o, rf_waddr_o, rf_wdata_o}, {26'd0, 1'b1, a[4:0], d});
    else
      chk(rf_we_o === 1'b0, req, {63'd0, rf_we_o}, 64'd0);
  endtask

  task automatic exp_dm(input bit we, input logic [31:0] a, input logic [31:0] d, input string req);
    if (we)
      chk(dm_we_o === 1'b1 && dm_addr_o === a && dm_wdata_o === d, req,
          {dm_addr_o, dm_wdata_o}, {a, d});
    else
      chk(dm_we_o === 1'b0, req, {63'd0, dm_we_o}, 64'd0);
  endtask

  task automatic fill_one(input bit to_d, input int a, input logic [31:0] d);
    @(negedge clk);
    fill_valid = 1'b1; fill_dmem = to_d; fill_addr = a[7:0]; fill_data = d;
    @(posedge clk);
    #1 fill_valid = 1'b0;
  endtask

  task automatic load_all(input int n);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < n; i++) fill_one(1'b0, i, prog[i]);
    for (int i = 0; i < 8; i++) fill_one(1'b1, i, dinit[i]);
  endtask

  task automatic start_run();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic next_cycle();
    @(negedge clk);
    #1;
  endtask

  logic [31:0] vals [8];

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h0000_0005;
    vals[6] = 32'hFFFF_FFFB; vals[7] = 32'h1234_5678;

    // R1: reset state
    #10;
    exp_pc(32'd0, "R1 pc in reset");
    chk(fill_ready === 1'b1, "R1 fill_ready in reset", {63'd0, fill_ready}, 64'd1);
    exp_rf(1'b0, 0, 0, "R1 no reg write in reset");
    exp_dm(1'b0, 0, 0, "R1 no store in reset");

    // R3/R5/R2: ALU sweep over every ordered operand pair for each operation
    for (int op = 0; op < 5; op++) begin
      logic [5:0] fcode;
      case (op)
        0: fcode = 6'h20; 1: fcode = 6'h22; 2: fcode = 6'h24;
        3: fcode = 6'h25; default: fcode = 6'h2A;
      endcase
      for (int i = 0; i < 8; i++) begin
        prog[i] = enc_i(6'h23, 0, i + 1, 4 * i);
        dinit[i] = vals[i];
      end
      for (int k = 0; k < 64; k++) prog[8 + k] = enc_r(k / 8 + 1, k % 8 + 1, 9 + k % 20, fcode);
      load_all(72);
      start_run();
      for (int i = 0; i < 8; i++) begin
        exp_pc(32'(4 * i), "R2 pc during loads");
        exp_rf(1'b1, i + 1, vals[i], "R5 load write-back");
        next_cycle();
      end
      for (int k = 0; k < 64; k++) begin
        exp_pc(32'(4 * (8 + k)), "R2 pc during alu ops");
        exp_rf(1'b1, 9 + k % 20, alu_ref(op, vals[k / 8], vals[k % 8]), "R3 alu result");
        next_cycle();
      end
    end

    // R1/R4/R5/R6/R8/R9: mixed memory program
    for (int i = 0; i < 8; i++) dinit[i] = 32'd0;
    dinit[0] = 32'd7; dinit[1] = 32'd9; dinit[2] = 32'h8000_0001;
    prog[0]  = enc_i(6'h23, 0, 1, 0);
    prog[1]  = enc_i(6'h23, 0, 2, 4);
    prog[2]  = enc_r(1, 2, 0, 6'h20);
    prog[3]  = enc_i(6'h23, 0, 0, 8);
    prog[4]  = enc_r(0, 1, 3, 6'h20);
    prog[5]  = enc_r(1, 2, 4, 6'h20);
    prog[6]  = enc_i(6'h2B, 4, 2, 8);
    prog[7]  = enc_i(6'h2B, 4, 1, -4);
    prog[8]  = enc_i(6'h23, 4, 6, -4);
    prog[9]  = enc_i(6'h23, 0, 7, 24);
    prog[10] = enc_i(6'h2B, 0, 0, 0);
    prog[11] = 32'hFC00_0000;
    prog[12] = enc_r(1, 2, 5, 6'h00);
    prog[13] = enc_i(6'h23, 0, 8, 0);
    prog[14] = enc_i(6'h23, 0, 9, 8);
    load_all(15);
    start_run();
    chk(fill_ready === 1'b0, "R1 fill_ready while running", {63'd0, fill_ready}, 64'd0);
    fill_valid = 1'b1; fill_dmem = 1'b1; fill_addr = 8'd2; fill_data = 32'hDEAD_BEEF;
    for (int c = 0; c < 15; c++) begin
      exp_pc(32'(4 * c), "R2 pc in memory program");
      case (c)
        0:  exp_rf(1'b1, 1, 32'd7, "R5 load r1");
        1:  exp_rf(1'b1, 2, 32'd9, "R5 load r2");
        2:  exp_rf(1'b0, 0, 0, "R4 add into r0 dropped");
        3:  exp_rf(1'b0, 0, 0, "R4 load into r0 dropped");
        4:  exp_rf(1'b1, 3, 32'd7, "R4 r0 reads zero");
        5:  exp_rf(1'b1, 4, 32'd16, "R3 add base");
        6:  begin exp_dm(1'b1, 32'd24, 32'd9, "R6 store positive offset");
                  exp_rf(1'b0, 0, 0, "R6 store writes no register"); end
        7:  exp_dm(1'b1, 32'd12, 32'd7, "R6 store negative offset");
        8:  exp_rf(1'b1, 6, 32'd7, "R6 load returns stored word");
        9:  exp_rf(1'b1, 7, 32'd9, "R6 load returns stored word");
        10: exp_dm(1'b1, 32'd0, 32'd0, "R4 r0 stored as zero");
        11: begin exp_rf(1'b0, 0, 0, "R8 unknown opcode no reg write");
                  exp_dm(1'b0, 0, 0, "R8 unknown opcode no store"); end
        12: begin exp_rf(1'b0, 0, 0, "R8 unknown funct no reg write");
                  exp_dm(1'b0, 0, 0, "R8 unknown funct no store"); end
        13: exp_rf(1'b1, 8, 32'd0, "R5 load after store");
        default: exp_rf(1'b1, 9, 32'h8000_0001, "R1 running fill ignored");
      endcase
      if (c != 6 && c != 7 && c != 10) exp_dm(1'b0, 0, 0, "R9 no store strobe");
      next_cycle();
    end
    fill_valid = 1'b0;
    exp_pc(32'd60, "R2 pc after memory program");

    // R7: branch trace
    for (int i = 0; i < 64; i++) prog[i] = enc_i(6'h2B, 0, 1, 0);
    prog[0]  = enc_i(6'h23, 0, 1, 0);
    prog[1]  = enc_i(6'h23, 0, 2, 4);
    prog[2]  = enc_i(6'h04, 0, 0, 2);
    prog[4]  = enc_i(6'h04, 1, 1, 8);
    prog[5]  = enc_i(6'h04, 1, 2, 5);
    prog[6]  = enc_i(6'h04, 0, 0, -3);
    prog[13] = 32'hFC00_0000;
    prog[14] = enc_r(1, 2, 3, 6'h22);
    load_all(64);
    start_run();
    begin
      int trace [9] = '{0, 4, 8, 20, 24, 16, 52, 56, 60};
      for (int c = 0; c < 9; c++) begin
        exp_pc(32'(trace[c]), "R7 branch pc trace");
        if (c >= 2 && c <= 6) begin
          exp_rf(1'b0, 0, 0, "R7 branch writes no register");
          exp_dm(1'b0, 0, 0, "R7 branch writes no store");
        end
        if (c == 7) exp_rf(1'b1, 3, 32'hFFFF_FFFE, "R3 subtract after branches");
        next_cycle();
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule